// File: doc/BRIEF.md
# Tag-Only Issue Queue With Read-Port Gated Selection

This block is a scheduling queue for an out-of-order core that keeps no operand data at all. Each slot holds an operation code, a destination physical register number and, for each of two sources, a 7-bit physical register tag together with a "used" flag and a "ready" flag. A slot becomes eligible once every source it uses is ready. A source can be marked ready when the slot is written, or later when a completing instruction broadcasts a matching tag on the result bus. Only the tag is taken from that bus, never the value.

Because operands are read from the register file only after an instruction is chosen, selection is limited by how many register-file read ports are free in the current cycle. A slot asks for one port for each source it uses. That holds even when the source was ready at dispatch, since the value still has to be read. Among the eligible slots whose port demand fits the free count, the oldest one is sent out. Its physical register numbers go to the register file and the slot is released at the following clock edge. Dispatch is refused while every slot is occupied.

Top module: `vfrs_station`

## Requirements
- R1: After reset, no slot is occupied: `iss_valid` is 0 and `disp_ready` is 1.
- R2: A dispatch accepted at a clock edge stores the op, destination tag and both source tags with their used and ready flags. The entry is not visible at the issue output in its own dispatch cycle. If eligible, it appears with exactly those fields in the next cycle.
- R3: A broadcast (`wb_valid`=1) whose `wb_tag` equals a pending, used source tag of an occupied slot sets that source ready at the clock edge. The slot can issue from the following cycle onward, never in the broadcast cycle itself. A non-matching tag wakes nothing.
- R4: A broadcast whose tag equals a source tag being dispatched in the same cycle marks that source ready in the newly written slot.
- R5: At most one slot issues per cycle. Among the eligible slots, the one dispatched earliest is chosen.
- R6: A slot's port demand is the number of its used sources (0, 1 or 2). A slot is eligible only if its demand is at most `rd_ports_free`. A younger slot with a smaller demand issues ahead of an older one whose demand does not fit.
- R7: A slot with no used sources has demand 0, so it issues even when `rd_ports_free` is 0.
- R8: When all 16 slots are occupied, `disp_ready` is 0. A dispatch offered then is dropped and never issues.
- R9: A slot that issues is released at the next clock edge. It issues exactly once, and its capacity is available to dispatch in the following cycle.
- R10: An unused source (used flag 0) counts as ready whatever its ready flag and tag are, and it is reported with used flag 0 at issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request this cycle |
| disp_ready | output | 1 | At least one slot is free; dispatch is accepted |
| disp_op | input | 8 | Operation code of the dispatched instruction |
| disp_dst | input | 7 | Destination physical register tag |
| disp_src0_tag | input | 7 | Source 0 physical register tag |
| disp_src0_use | input | 1 | Source 0 is a register operand |
| disp_src0_rdy | input | 1 | Source 0 value is already available |
| disp_src1_tag | input | 7 | Source 1 physical register tag |
| disp_src1_use | input | 1 | Source 1 is a register operand |
| disp_src1_rdy | input | 1 | Source 1 value is already available |
| wb_valid | input | 1 | A result tag is broadcast this cycle |
| wb_tag | input | 7 | Broadcast result tag |
| rd_ports_free | input | 2 | Register-file read ports available this cycle |
| iss_valid | output | 1 | A slot is selected this cycle |
| iss_op | output | 8 | Op of the selected slot |
| iss_dst | output | 7 | Destination tag of the selected slot |
| iss_src0_tag | output | 7 | Source 0 tag to read from the register file |
| iss_src0_use | output | 1 | Source 0 read is needed |
| iss_src1_tag | output | 7 | Source 1 tag to read from the register file |
| iss_src1_use | output | 1 | Source 1 read is needed |

## Verification
The issue output depends combinationally on the stored slots and on `rd_ports_free`. A port-count change therefore shows in the same cycle. A dispatch or a wakeup shows one cycle later, after the edge that registers it, and a selected slot disappears one cycle after it is shown. The bench drives every input just after the falling edge and samples one time unit later, well before the next rising edge. Each expectation is placed in the cycle that follows the counted register stages: dispatch visible at +1, wakeup eligible at +1 after the broadcast edge, release at +1 after selection. Every check also confirms that the output is still quiet in the cycle before a result is due.

// File: rtl/vfrs_pkg.sv
package vfrs_pkg;

    localparam int TAG_W = 7;
    localparam int OP_W  = 8;
    localparam int NSRC  = 2;

    typedef logic [TAG_W-1:0] ptag_t;

    // One queue slot: tags and flags only, no operand values
    typedef struct packed {
        logic                 live;
        logic [OP_W-1:0]      op;
        ptag_t                dst;
        ptag_t [NSRC-1:0]     src;
        logic  [NSRC-1:0]     uses;
        logic  [NSRC-1:0]     rdy;
    } slot_t;

endpackage

// File: rtl/vfrs_slot_pick.sv
module vfrs_slot_pick #(
    parameter  int N  = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  busy,
    output logic          found,
    output logic [IW-1:0] idx
);

    // Lowest-numbered vacant slot
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/vfrs_age_order.sv
module vfrs_age_order #(
    parameter  int N  = 16,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_en,
    input  logic [IW-1:0] alloc_idx,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic          grant_vld,
    output logic [IW-1:0] grant_idx
);

    // older[i][j] = 1 : slot i was written before slot j
    typedef struct packed {
        logic [N-1:0][N-1:0] older;
    } age_t;

    age_t         st_d, st_q;
    logic [N-1:0] blocked;

    always_comb begin
        st_d = st_q;
        if (alloc_en) begin
            for (int j = 0; j < N; j++) begin
                st_d.older[alloc_idx][j] = 1'b0;
                st_d.older[j][alloc_idx] = (j != int'(alloc_idx));
            end
        end

        grant     = '0;
        grant_idx = '0;
        for (int i = 0; i < N; i++) begin
            blocked[i] = 1'b0;
            for (int j = 0; j < N; j++) begin
                blocked[i] = blocked[i] | (req[j] & st_q.older[j][i]);
            end
            grant[i] = req[i] & ~blocked[i];
        end
        for (int i = 0; i < N; i++) begin
            if (grant[i]) grant_idx = IW'(i);
        end
        grant_vld = |grant;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: never more than one winner
    a_r5_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R5: a request that exists always yields a winner
    a_r5_grant_when_req: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> grant_vld);

endmodule

// File: rtl/vfrs_station.sv
module vfrs_station
    import vfrs_pkg::*;
#(
    parameter  int DEPTH    = 16,
    parameter  int RD_PORTS = 2,
    localparam int IW       = $clog2(DEPTH),
    localparam int CNT_W    = $clog2(RD_PORTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid,
    output logic              disp_ready,
    input  logic [OP_W-1:0]   disp_op,
    input  logic [TAG_W-1:0]  disp_dst,
    input  logic [TAG_W-1:0]  disp_src0_tag,
    input  logic              disp_src0_use,
    input  logic              disp_src0_rdy,
    input  logic [TAG_W-1:0]  disp_src1_tag,
    input  logic              disp_src1_use,
    input  logic              disp_src1_rdy,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [CNT_W-1:0]  rd_ports_free,
    output logic              iss_valid,
    output logic [OP_W-1:0]   iss_op,
    output logic [TAG_W-1:0]  iss_dst,
    output logic [TAG_W-1:0]  iss_src0_tag,
    output logic              iss_src0_use,
    output logic [TAG_W-1:0]  iss_src1_tag,
    output logic              iss_src1_use
);

    typedef struct packed {
        slot_t [DEPTH-1:0] slot;
    } rs_state_t;

    rs_state_t          st_d, st_q;
    logic [DEPTH-1:0]   live_vec;
    logic [DEPTH-1:0]   elig;
    logic [DEPTH-1:0]   grant;
    logic               grant_vld;
    logic [IW-1:0]      grant_idx;
    logic               have_free;
    logic [IW-1:0]      alloc_idx;
    logic               do_alloc;
    slot_t              new_slot;
    slot_t              sel;
    ptag_t [NSRC-1:0]   in_src;
    logic  [NSRC-1:0]   in_use;
    logic  [NSRC-1:0]   in_rdy;

    assign in_src = {disp_src1_tag, disp_src0_tag};
    assign in_use = {disp_src1_use, disp_src0_use};
    assign in_rdy = {disp_src1_rdy, disp_src0_rdy};

    // Eligibility: all used sources ready and port demand fits
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            int  need;
            logic srcs_ok;
            need    = 0;
            srcs_ok = 1'b1;
            for (int s = 0; s < NSRC; s++) begin
                need    = need + int'(st_q.slot[i].uses[s]);
                srcs_ok = srcs_ok & (st_q.slot[i].rdy[s] | ~st_q.slot[i].uses[s]);
            end
            live_vec[i] = st_q.slot[i].live;
            elig[i]     = st_q.slot[i].live & srcs_ok & (need <= int'(rd_ports_free));
        end
    end

    vfrs_slot_pick #(.N(DEPTH)) u_pick (
        .busy  (live_vec),
        .found (have_free),
        .idx   (alloc_idx)
    );

    vfrs_age_order #(.N(DEPTH)) u_age (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (do_alloc),
        .alloc_idx (alloc_idx),
        .req       (elig),
        .grant     (grant),
        .grant_vld (grant_vld),
        .grant_idx (grant_idx)
    );

    assign disp_ready = have_free;

    // Next-state: wakeup, release, write
    always_comb begin
        st_d     = st_q;
        do_alloc = disp_valid & have_free;

        new_slot      = '0;
        new_slot.live = 1'b1;
        new_slot.op   = disp_op;
        new_slot.dst  = disp_dst;
        for (int s = 0; s < NSRC; s++) begin
            new_slot.src[s]  = in_src[s];
            new_slot.uses[s] = in_use[s];
            new_slot.rdy[s]  = in_rdy[s] | (wb_valid && (in_src[s] == wb_tag));
        end

        for (int i = 0; i < DEPTH; i++) begin
            for (int s = 0; s < NSRC; s++) begin
                if (wb_valid && (st_q.slot[i].src[s] == wb_tag)) begin
                    st_d.slot[i].rdy[s] = 1'b1;
                end
            end
            if (grant[i]) st_d.slot[i].live = 1'b0;
        end

        if (do_alloc) st_d.slot[alloc_idx] = new_slot;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Issue output: physical register numbers go to the register file
    always_comb begin
        sel          = st_q.slot[grant_idx];
        iss_valid    = grant_vld;
        iss_op       = sel.op;
        iss_dst      = sel.dst;
        iss_src0_tag = sel.src[0];
        iss_src0_use = sel.uses[0];
        iss_src1_tag = sel.src[1];
        iss_src1_use = sel.uses[1];
    end

    // R2: accepted dispatch occupies the chosen slot
    a_r2_slot_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_ready) |=> live_vec[$past(alloc_idx)]);

    // R6: issued read demand never exceeds free ports
    a_r6_port_budget: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> ((int'(iss_src0_use) + int'(iss_src1_use)) <= int'(rd_ports_free)));

    // R9: selected slot is vacant at the next cycle
    a_r9_released: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |=> ((live_vec & $past(grant)) == '0));

    // R8: refused dispatch adds no occupancy
    a_r8_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !disp_ready) |=>
            (($countones(live_vec) + int'($past(iss_valid))) == $past($countones(live_vec))));

    // R3: matching broadcast sets the pending source ready
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_wake_chk
        for (genvar gs = 0; gs < NSRC; gs++) begin : g_src
            a_r3_wake_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
                (wb_valid && st_q.slot[gi].live && st_q.slot[gi].uses[gs] &&
                 (st_q.slot[gi].src[gs] == wb_tag) && !grant[gi])
                |=> st_q.slot[gi].rdy[gs]);
        end
    end

endmodule

// File: tb/vfrs_station_tb_top.sv
module vfrs_station_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       disp_valid;
    logic       disp_ready;
    logic [7:0] disp_op;
    logic [6:0] disp_dst;
    logic [6:0] disp_src0_tag;
    logic       disp_src0_use;
    logic       disp_src0_rdy;
    logic [6:0] disp_src1_tag;
    logic       disp_src1_use;
    logic       disp_src1_rdy;
    logic       wb_valid;
    logic [6:0] wb_tag;
    logic [1:0] rd_ports_free;
    logic       iss_valid;
    logic [7:0] iss_op;
    logic [6:0] iss_dst;
    logic [6:0] iss_src0_tag;
    logic       iss_src0_use;
    logic [6:0] iss_src1_tag;
    logic       iss_src1_use;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vfrs_station dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .disp_valid    (disp_valid),
        .disp_ready    (disp_ready),
        .disp_op       (disp_op),
        .disp_dst      (disp_dst),
        .disp_src0_tag (disp_src0_tag),
        .disp_src0_use (disp_src0_use),
        .disp_src0_rdy (disp_src0_rdy),
        .disp_src1_tag (disp_src1_tag),
        .disp_src1_use (disp_src1_use),
        .disp_src1_rdy (disp_src1_rdy),
        .wb_valid      (wb_valid),
        .wb_tag        (wb_tag),
        .rd_ports_free (rd_ports_free),
        .iss_valid     (iss_valid),
        .iss_op        (iss_op),
        .iss_dst       (iss_dst),
        .iss_src0_tag  (iss_src0_tag),
        .iss_src0_use  (iss_src0_use),
        .iss_src1_tag  (iss_src1_tag),
        .iss_src1_use  (iss_src1_use)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic put_disp(input logic [7:0] op, input logic [6:0] dst,
                            input logic [6:0] t0, input logic u0, input logic r0,
                            input logic [6:0] t1, input logic u1, input logic r1);
        disp_valid    = 1'b1;
        disp_op       = op;
        disp_dst      = dst;
        disp_src0_tag = t0;
        disp_src0_use = u0;
        disp_src0_rdy = r0;
        disp_src1_tag = t1;
        disp_src1_use = u1;
        disp_src1_rdy = r1;
    endtask

    task automatic expect_issue(input string req, input logic [7:0] op);
        #1;
        chk({req, " iss_valid"}, 32'(iss_valid), 32'd1);
        chk({req, " iss_op"}, 32'(iss_op), 32'(op));
    endtask

    task automatic expect_quiet(input string req);
        #1;
        chk({req, " iss_valid low"}, 32'(iss_valid), 32'd0);
    endtask

    task automatic t_reset();
        #1;
        chk("R1 iss_valid after reset", 32'(iss_valid), 32'd0);
        chk("R1 disp_ready after reset", 32'(disp_ready), 32'd1);
    endtask

    task automatic t_basic();
        rd_ports_free = 2'd2;
        put_disp(8'h11, 7'd5, 7'd3, 1'b1, 1'b1, 7'd4, 1'b1, 1'b1);
        expect_quiet("R2 same cycle");
        step();
        disp_valid = 1'b0;
        expect_issue("R2", 8'h11);
        chk("R2 dst", 32'(iss_dst), 32'd5);
        chk("R2 src0 tag", 32'(iss_src0_tag), 32'd3);
        chk("R2 src1 tag", 32'(iss_src1_tag), 32'd4);
        chk("R2 uses", {30'd0, iss_src1_use, iss_src0_use}, 32'd3);
        step();
        expect_quiet("R9 single issue");
    endtask

    task automatic t_wake();
        rd_ports_free = 2'd2;
        put_disp(8'h22, 7'd6, 7'd10, 1'b1, 1'b0, 7'd11, 1'b1, 1'b1);
        step();
        disp_valid = 1'b0;
        wb_valid   = 1'b1;
        wb_tag     = 7'd12;
        expect_quiet("R3 pending");
        step();
        wb_tag = 7'd10;
        expect_quiet("R3 wrong tag no wake");
        step();
        wb_valid = 1'b0;
        expect_issue("R3 woken", 8'h22);
        step();
        expect_quiet("R3 after issue");
    endtask

    task automatic t_same_cycle();
        rd_ports_free = 2'd2;
        put_disp(8'h33, 7'd7, 7'd20, 1'b1, 1'b0, 7'd0, 1'b0, 1'b0);
        wb_valid = 1'b1;
        wb_tag   = 7'd20;
        step();
        disp_valid = 1'b0;
        wb_valid   = 1'b0;
        expect_issue("R4", 8'h33);
        step();
        expect_quiet("R4 after");
    endtask

    task automatic t_age();
        rd_ports_free = 2'd0;
        put_disp(8'h41, 7'd1, 7'd30, 1'b1, 1'b0, 7'd0, 1'b0, 1'b0);
        step();
        put_disp(8'h42, 7'd2, 7'd31, 1'b1, 1'b1, 7'd0, 1'b0, 1'b0);
        step();
        put_disp(8'h43, 7'd3, 7'd32, 1'b1, 1'b1, 7'd0, 1'b0, 1'b0);
        step();
        disp_valid = 1'b0;
        wb_valid   = 1'b1;
        wb_tag     = 7'd30;
        expect_quiet("R6 no ports");
        step();
        wb_valid      = 1'b0;
        rd_ports_free = 2'd2;
        expect_issue("R5 oldest first", 8'h41);
        step();
        expect_issue("R5 second", 8'h42);
        step();
        expect_issue("R5 third", 8'h43);
        step();
        expect_quiet("R5 drained");
    endtask

    task automatic t_ports();
        rd_ports_free = 2'd0;
        put_disp(8'h51, 7'd1, 7'd40, 1'b1, 1'b1, 7'd41, 1'b1, 1'b1);
        step();
        put_disp(8'h52, 7'd2, 7'd42, 1'b1, 1'b1, 7'd0, 1'b0, 1'b0);
        step();
        disp_valid    = 1'b0;
        rd_ports_free = 2'd1;
        expect_issue("R6 younger fits", 8'h52);
        step();
        expect_quiet("R6 two-source waits");
        rd_ports_free = 2'd2;
        expect_issue("R6 two ports", 8'h51);
        step();
        expect_quiet("R6 after");
    endtask

    task automatic t_zero_src();
        rd_ports_free = 2'd0;
        put_disp(8'h61, 7'd9, 7'd99, 1'b0, 1'b0, 7'd98, 1'b0, 1'b0);
        step();
        disp_valid = 1'b0;
        expect_issue("R7 zero ports", 8'h61);
        chk("R10 unused flags", {30'd0, iss_src1_use, iss_src0_use}, 32'd0);
        step();
        expect_quiet("R7 after");
    endtask

    task automatic t_full();
        rd_ports_free = 2'd0;
        for (int k = 0; k < 16; k++) begin
            put_disp(8'h70 + 8'(k), 7'(k), 7'(k + 50), 1'b1, 1'b1, 7'd0, 1'b0, 1'b0);
            #1;
            chk("R8 ready before full", 32'(disp_ready), 32'd1);
            step();
        end
        put_disp(8'hEE, 7'd0, 7'd90, 1'b1, 1'b1, 7'd0, 1'b0, 1'b0);
        #1;
        chk("R8 disp_ready low when full", 32'(disp_ready), 32'd0);
        step();
        disp_valid    = 1'b0;
        rd_ports_free = 2'd2;
        for (int k = 0; k < 16; k++) begin
            expect_issue("R8 drain order", 8'h70 + 8'(k));
            if (k == 1) chk("R9 space after release", 32'(disp_ready), 32'd1);
            step();
        end
        expect_quiet("R8 dropped dispatch");
    endtask

    initial begin
        rst_n         = 1'b0;
        disp_valid    = 1'b0;
        disp_op       = '0;
        disp_dst      = '0;
        disp_src0_tag = '0;
        disp_src0_use = 1'b0;
        disp_src0_rdy = 1'b0;
        disp_src1_tag = '0;
        disp_src1_use = 1'b0;
        disp_src1_rdy = 1'b0;
        wb_valid      = 1'b0;
        wb_tag        = '0;
        rd_ports_free = '0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_basic();
        t_wake();
        t_same_cycle();
        t_age();
        t_ports();
        t_zero_src();
        t_full();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule